// File: doc/BRIEF.md
# Trigger Event-Action Matrix

This block qualifies trigger signals for an on-chip trace unit. A pool of trigger lines, made of external triggers plus the block's own counter triggers, feeds a bank of AND terms. Each AND term is hard-wired to four pool lines, and software picks a literal mode for each of them. The AND outputs are the event triggers. An OR plane turns the events into action outputs such as trace enable, debug request or outgoing cross trigger. On each OR input an event can be left out, passed through, negated, or replaced by its one-cycle rising-edge pulse. Because the edge is taken after the AND, a single OR input can detect the instant a whole conjunction becomes true.

Two saturating counters take increment and clear commands, each formed as an AND of a selectable set of events. When a counter equals its limit it raises a counter trigger. That trigger is fed back into the pool, so the counters can hold the state of a small trace state machine whose transitions are built from events. Configuration is written one word per cycle through an address/data/write-enable port. It lands in a shadow bank and is copied into the active bank on the next clock, so no term ever sees half of a write.

Literal modes of an AND input are IGNORE (the input is forced true), DIRECT and INVERT. OR-input modes are OFF, DIRECT, NEGATE and RISE. Each counter moves through HOLD, STEP, CLEAR and SATURATED: it steps on an increment, falls to CLEAR on a clear (which wins over an increment), and stays SATURATED at all-ones until it is cleared.

Top module: `trig_event_matrix`

## Requirements
- R1: After reset every action output is low, both counters read zero with a zero limit, and so both counter triggers are high.
- R2: AND term t reads pool lines in a fixed order of four. Term 0 reads 0,1,2,3. Term 1 reads 0,2,4,6. Term 2 reads 1,2,4,6. Term 3 reads 3,4,5,6. Each term t of 4 and above reads (7+4*(t-4)+k) mod 16 for k=0..3. Pool lines 0..13 are ext_trig, line 14 is counter trigger 0 and line 15 is counter trigger 1.
- R3: Config word t (addresses 0..7) bits [2k+1:2k] set the mode of literal k of term t: 00 or 11 ignore (true), 01 direct, 10 inverted. A term is the AND of its four literals.
- R4: Bit 8 of a term word enables the term. A disabled term drives its event low whatever its literals are.
- R5: Word 8+j sets action j. Bits [2i+1:2i] set the mode for event i: 00 off, 01 direct, 10 negated, 11 rising edge. The action is the OR of all contributions.
- R6: In rising-edge mode, the contribution is high for exactly one cycle, in the first cycle in which the event is high after being low in the previous cycle.
- R7: Word 12+c bits [7:0] are the increment mask of counter c. When the mask is non-zero and every masked event is high, the counter steps by one per clock. It saturates at all-ones.
- R8: Bits [15:8] of word 12+c are the clear mask, which works like the increment mask. A clear sets the counter to zero and wins over a simultaneous increment.
- R9: Counter trigger c is high exactly when counter c equals its limit word (address 14+c). The trigger is visible on cnt_hit and on its pool line.
- R10: A write sampled at clock edge E has no effect on the outputs after edge E. It takes effect after edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| ext_trig | input | 14 | External trigger lines (pool lines 0..13) |
| act_out | output | 4 | Action outputs |
| cnt_hit | output | 2 | Counter triggers (counter equals limit) |

## Verification
The assertions assume that reset is asserted from time zero and that cfg_we stays low while reset is active. This lets the two-cycle configuration history and the edge registers start from known values. They also take the trigger and configuration inputs as synchronous, changing only between rising edges. The bench drives every input on the falling edge and samples the outputs shortly after. It keeps cfg_we low except during its single-cycle write bursts, and it always addresses mapped configuration words.

// File: rtl/trig_matrix_pkg.sv
package trig_matrix_pkg;

    // Literal mode of one AND-term input
    typedef enum logic [1:0] {
        LIT_IGNORE   = 2'b00,
        LIT_DIRECT   = 2'b01,
        LIT_INVERT   = 2'b10,
        LIT_IGNORE_B = 2'b11
    } lit_sel_e;

    // Mode of one OR-plane input
    typedef enum logic [1:0] {
        ORM_OFF    = 2'b00,
        ORM_DIRECT = 2'b01,
        ORM_NEGATE = 2'b10,
        ORM_RISE   = 2'b11
    } or_mode_e;

    // Fixed pool line read by literal k of term t
    function automatic int term_src(input int t, input int k, input int n);
        case (t)
            0:       return k % n;
            1:       return (2 * k) % n;
            2:       return ((k == 0) ? 1 : 2 * k) % n;
            3:       return ((k == 0) ? 3 : k + 3) % n;
            default: return (7 + 4 * (t - 4) + k) % n;
        endcase
    endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank #(
    parameter int N_REG = 16,
    parameter int DW    = 16,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [N_REG*DW-1:0] cfg_flat
);

    logic [N_REG*DW-1:0] shadow_q;
    logic [N_REG*DW-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            for (int r = 0; r < N_REG; r++) begin
                if (we && addr == AW'(r)) begin
                    shadow_q[r*DW +: DW] <= wdata;
                end
            end
            active_q <= shadow_q;
        end
    end

    assign cfg_flat = active_q;

    // R10: the active bank moves only two edges after a write strobe
    a_r10_active_lags_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we, 2) |-> $stable(active_q));

endmodule

// File: rtl/trig_and_plane.sv
module trig_and_plane
    import trig_matrix_pkg::*;
#(
    parameter int N_IN       = 16,
    parameter int N_TERM     = 8,
    parameter int N_LIT      = 4,
    parameter bit GATE_TERMS = 1'b1
) (
    input  logic [N_IN-1:0]           pool,
    input  logic [N_TERM*2*N_LIT-1:0] sel_flat,
    input  logic [N_TERM-1:0]         term_en,
    output logic [N_TERM-1:0]         ev
);

    logic [N_TERM*N_LIT-1:0] lit;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        for (genvar k = 0; k < N_LIT; k++) begin : g_lit
            localparam int SRC = term_src(t, k, N_IN);
            always_comb begin
                unique case (lit_sel_e'(sel_flat[(t*N_LIT+k)*2 +: 2]))
                    LIT_DIRECT: lit[t*N_LIT+k] = pool[SRC];
                    LIT_INVERT: lit[t*N_LIT+k] = ~pool[SRC];
                    default:    lit[t*N_LIT+k] = 1'b1;
                endcase
            end
        end
        if (GATE_TERMS) begin : g_gate
            assign ev[t] = term_en[t] & (&lit[t*N_LIT +: N_LIT]);
        end else begin : g_nogate
            assign ev[t] = &lit[t*N_LIT +: N_LIT];
        end
    end

endmodule

// File: rtl/trig_or_plane.sv
module trig_or_plane
    import trig_matrix_pkg::*;
#(
    parameter int N_TERM = 8,
    parameter int N_ACT  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TERM-1:0]         ev,
    input  logic [N_ACT*2*N_TERM-1:0] mode_flat,
    output logic [N_ACT-1:0]          act
);

    logic [N_TERM-1:0] prev_q;
    logic [N_TERM-1:0] rise;

    // Previous value starts high so a level already true at reset gives no pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= ev;
    end

    assign rise = ev & ~prev_q;

    for (genvar j = 0; j < N_ACT; j++) begin : g_act
        always_comb begin
            act[j] = 1'b0;
            for (int i = 0; i < N_TERM; i++) begin
                unique case (or_mode_e'(mode_flat[(j*N_TERM+i)*2 +: 2]))
                    ORM_OFF:    act[j] = act[j];
                    ORM_DIRECT: act[j] = act[j] | ev[i];
                    ORM_NEGATE: act[j] = act[j] | ~ev[i];
                    ORM_RISE:   act[j] = act[j] | rise[i];
                endcase
            end
        end
    end

    // R6: an edge pulse never lasts two cycles
    for (genvar i = 0; i < N_TERM; i++) begin : g_chk
        a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
    parameter int N_TERM = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TERM-1:0] ev,
    input  logic [N_TERM-1:0] inc_mask,
    input  logic [N_TERM-1:0] clr_mask,
    input  logic [CNT_W-1:0]  limit,
    output logic              hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef enum logic [1:0] {
        CS_HOLD, CS_STEP, CS_CLEAR, CS_SATURATED
    } cnt_state_e;

    logic             inc_req;
    logic             clr_req;
    logic [CNT_W-1:0] cnt_q;
    cnt_state_e       nxt_op;

    assign inc_req = (|inc_mask) & (&(ev | ~inc_mask));
    assign clr_req = (|clr_mask) & (&(ev | ~clr_mask));

    always_comb begin
        if (clr_req)                         nxt_op = CS_CLEAR;
        else if (inc_req && cnt_q == CNT_MAX) nxt_op = CS_SATURATED;
        else if (inc_req)                    nxt_op = CS_STEP;
        else                                 nxt_op = CS_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (nxt_op)
                CS_CLEAR:     cnt_q <= '0;
                CS_STEP:      cnt_q <= cnt_q + CNT_W'(1);
                CS_SATURATED: cnt_q <= CNT_MAX;
                CS_HOLD:      cnt_q <= cnt_q;
            endcase
        end
    end

    assign hit = (cnt_q == limit);

    // R8: clear dominates
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> cnt_q == '0);
    // R7: single step on increment
    a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_req && !clr_req && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    // R7: no wrap past all-ones
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_req) |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/trig_event_matrix.sv
module trig_event_matrix #(
    parameter int N_IN       = 16,
    parameter int N_TERM     = 8,
    parameter int N_ACT      = 4,
    parameter int N_CNT      = 2,
    parameter int CNT_W      = 16,
    parameter int DW         = 16,
    parameter bit GATE_TERMS = 1'b1,
    localparam int N_EXT     = N_IN - N_CNT,
    localparam int N_REG     = N_TERM + N_ACT + 2 * N_CNT,
    localparam int AW        = $clog2(N_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic [N_EXT-1:0] ext_trig,
    output logic [N_ACT-1:0] act_out,
    output logic [N_CNT-1:0] cnt_hit
);

    localparam int N_LIT     = 4;
    localparam int TERM_BASE = 0;
    localparam int ACT_BASE  = TERM_BASE + N_TERM;
    localparam int CTL_BASE  = ACT_BASE + N_ACT;
    localparam int LIM_BASE  = CTL_BASE + N_CNT;
    localparam int SPARE_W   = DW - 2 * N_LIT - 1;

    logic [N_REG*DW-1:0]         cfg_flat;
    logic [N_IN-1:0]             pool;
    logic [N_TERM*2*N_LIT-1:0]   and_sel;
    logic [N_TERM-1:0]           term_en;
    logic [N_TERM-1:0]           ev;
    logic [N_ACT*2*N_TERM-1:0]   or_mode;
    logic [N_TERM-1:0]           unused_term_bits;

    trig_cfg_bank #(.N_REG(N_REG), .DW(DW), .AW(AW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg_flat (cfg_flat)
    );

    assign pool = {cnt_hit, ext_trig};

    for (genvar t = 0; t < N_TERM; t++) begin : g_tw
        assign and_sel[t*2*N_LIT +: 2*N_LIT] = cfg_flat[(TERM_BASE+t)*DW +: 2*N_LIT];
        assign term_en[t]                    = cfg_flat[(TERM_BASE+t)*DW + 2*N_LIT];
        assign unused_term_bits[t]           = ^cfg_flat[(TERM_BASE+t)*DW + 2*N_LIT + 1 +: SPARE_W];
    end

    for (genvar j = 0; j < N_ACT; j++) begin : g_aw
        assign or_mode[j*2*N_TERM +: 2*N_TERM] = cfg_flat[(ACT_BASE+j)*DW +: 2*N_TERM];
    end

    trig_and_plane #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_LIT(N_LIT), .GATE_TERMS(GATE_TERMS)
    ) u_and (
        .pool     (pool),
        .sel_flat (and_sel),
        .term_en  (term_en),
        .ev       (ev)
    );

    trig_or_plane #(.N_TERM(N_TERM), .N_ACT(N_ACT)) u_or (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .mode_flat (or_mode),
        .act       (act_out)
    );

    for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
        trig_counter #(.N_TERM(N_TERM), .CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev),
            .inc_mask (cfg_flat[(CTL_BASE+c)*DW +: N_TERM]),
            .clr_mask (cfg_flat[(CTL_BASE+c)*DW + N_TERM +: N_TERM]),
            .limit    (cfg_flat[(LIM_BASE+c)*DW +: CNT_W]),
            .hit      (cnt_hit[c])
        );
    end

endmodule

// File: tb/test_trig_event_matrix.sv
module test_trig_event_matrix;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [13:0] ext_trig = '0;
    logic [3:0]  act_out;
    logic [1:0]  cnt_hit;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trig_event_matrix i_trig_event_matrix (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ext_trig  (ext_trig),
        .act_out   (act_out),
        .cnt_hit   (cnt_hit)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; ext_trig = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Write, then wait for the active bank to take it; ends on a falling edge
    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic drive(input int e);
        ext_trig = 14'(e);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 actions", 32'(act_out), 32'h0);
        chk("R1 counter triggers", 32'(cnt_hit), 32'h3);
    endtask

    task automatic t_mapping();
        do_reset();
        wr(2, 'h155);      // term2 all direct: lines 1,2,4,6
        wr(10, 'h0010);    // action2 <- event2
        wr(7, 'h155);      // term7 all direct: lines 3,4,5,6
        wr(11, 'h4000);    // action3 <- event7
        drive('h56); chk("R2 term2 lines 1,2,4,6", 32'(act_out[2]), 1);
        drive('h55); chk("R2 term2 ignores line 0", 32'(act_out[2]), 0);
        drive('h78); chk("R2 term7 lines 3..6", 32'(act_out[3]), 1);
        drive('h70); chk("R2 term7 needs line 3", 32'(act_out[3]), 0);
        drive(0);
    endtask

    task automatic t_lit_modes();
        do_reset();
        wr(3, 'h1C9);      // term3: line3 direct, line4 inverted, lines 5,6 ignored
        wr(9, 'h0040);     // action1 <- event3
        drive('h08); chk("R3 direct and inverted", 32'(act_out[1]), 1);
        drive('h18); chk("R3 inverted literal blocks", 32'(act_out[1]), 0);
        drive('h00); chk("R3 direct literal blocks", 32'(act_out[1]), 0);
        drive('h68); chk("R3 ignored literals", 32'(act_out[1]), 1);
        drive(0);
    endtask

    task automatic t_gate();
        do_reset();
        wr(8, 'h0001);     // action0 <- event0
        wr(0, 'h000);      // term0 all ignored, disabled
        drive(0); chk("R4 disabled term low", 32'(act_out[0]), 0);
        wr(0, 'h100);
        #1; chk("R4 enabled empty term high", 32'(act_out[0]), 1);
    endtask

    task automatic t_or_modes();
        do_reset();
        wr(0, 'h101);      // event0 = line0
        wr(1, 'h104);      // event1 = line2
        wr(8, 'h0002);     // action0 = not event0
        wr(9, 'h0005);     // action1 = event0 | event1
        drive('h0); chk("R5 negate of low", 32'(act_out[0]), 1);
        chk("R5 OR both low", 32'(act_out[1]), 0);
        drive('h1); chk("R5 negate of high", 32'(act_out[0]), 0);
        chk("R5 OR first input", 32'(act_out[1]), 1);
        drive('h4); chk("R5 OR second input", 32'(act_out[1]), 1);
        chk("R5 off mode contributes nothing", 32'(act_out[2]), 0);
        drive(0);
    endtask

    task automatic t_edge();
        do_reset();
        wr(0, 'h101);
        wr(8, 'h0003);     // action0 = rise(event0)
        drive('h1); chk("R6 pulse on rise", 32'(act_out[0]), 1);
        @(negedge clk); #1; chk("R6 pulse ends", 32'(act_out[0]), 0);
        @(negedge clk); drive('h0); chk("R6 no pulse on fall", 32'(act_out[0]), 0);
        @(negedge clk); drive('h1); chk("R6 second pulse", 32'(act_out[0]), 1);
        @(negedge clk); drive('h0);
    endtask

    task automatic t_count_clear();
        do_reset();
        wr(0, 'h101);      // event0 = line0
        wr(12, 'h0001);    // counter0 increments on event0
        wr(14, 3);         // limit0 = 3
        chk("R9 hit low below limit", 32'(cnt_hit[0]), 0);
        drive('h1);
        @(negedge clk); #1; chk("R7 count 1", 32'(cnt_hit[0]), 0);
        @(negedge clk); #1; chk("R7 count 2", 32'(cnt_hit[0]), 0);
        @(negedge clk); drive('h0); chk("R9 hit at limit", 32'(cnt_hit[0]), 1);
        @(negedge clk); #1; chk("R7 hold without increment", 32'(cnt_hit[0]), 1);
        wr(1, 'h104);      // event1 = line2
        wr(12, 'h0201);    // clear on event1
        drive('h5);
        @(negedge clk); drive('h0); chk("R8 clear beats increment", 32'(cnt_hit[0]), 0);
        wr(14, 0);
        #1; chk("R8 count is zero", 32'(cnt_hit[0]), 1);
    endtask

    task automatic t_feedback();
        do_reset();
        wr(5, 'h140);      // term5 literal3 = pool line 14 (counter0 trigger)
        wr(8, 'h0400);     // action0 <- event5
        chk("R9 pool sees hit", 32'(act_out[0]), 1);
        wr(14, 5);
        #1; chk("R9 pool sees miss", 32'(act_out[0]), 0);
        chk("R9 counter1 unaffected", 32'(cnt_hit[1]), 1);
    endtask

    task automatic t_cfg_timing();
        do_reset();
        wr(8, 'h0001);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 16'h0100;
        @(negedge clk);
        cfg_we = 1'b0; #1;
        chk("R10 not yet active", 32'(act_out[0]), 0);
        @(negedge clk); #1;
        chk("R10 active one cycle later", 32'(act_out[0]), 1);
    endtask

    task automatic t_saturate();
        do_reset();
        wr(0, 'h101);
        wr(12, 'h0001);
        wr(14, 'hFFFF);
        drive('h1);
        repeat (65535) @(negedge clk);
        #1; chk("R7 reaches all-ones", 32'(cnt_hit[0]), 1);
        repeat (3) @(negedge clk);
        #1; chk("R7 saturates", 32'(cnt_hit[0]), 1);
        drive('h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mapping();
        t_lit_modes();
        t_gate();
        t_or_modes();
        t_edge();
        t_count_clear();
        t_feedback();
        t_cfg_timing();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule